// File: doc/BRIEF.md
# Stack-Machine Execute Core

This block is a small sequential processor core. It reads its program one byte per cycle from a byte-wide program store and executes a short list of operations. These operations move 16-bit values between an immediate argument, a temporary register, a set of selectable registers and a data stack. The stack lives in word memory behind a memory-mapped bus. That bus has an address, a write value, a write strobe and combinational read data. The stack pointer is a slot index, and the bus address of a slot is a fixed base plus that index, wrapping at 16 bits.

Every instruction begins with one opcode byte. When bit 7 of that byte is set, the instruction is a single byte, its operation code is the low seven bits, and its argument is zero. When bit 7 is clear, two more bytes follow and hold the argument, high byte first. The core runs as a four-state loop: opcode fetch, argument high fetch, argument low fetch, execute. It stops once its program counter holds 0xFFFF. From then on every register is held and the halted output stays high until reset. A program therefore ends by loading 0xFFFF into the program counter.

Top module: `stk_core`

## Requirements
- R1: Synchronous active-high reset clears the program counter, the stack pointer, the temporary register and all general registers. After reset the core fetches from address 0, halted is low and no bus write is made.
- R2: An opcode byte with bit 7 set is a one-byte instruction whose operation is bits 6:0 and whose argument is 0. It takes two cycles (fetch, execute). Any other opcode byte is followed by a big-endian 16-bit argument and takes four cycles. The program counter advances by one for each byte fetched.
- R3: Operation 0x01 writes the argument to the slot at the stack pointer and then increments the stack pointer, with 16-bit wraparound.
- R4: Operation 0x02 decrements the stack pointer with wraparound, then writes 0 to the slot it now selects.
- R5: Operation 0x03 loads the argument into the temporary register. Operation 0x04 loads the temporary register from the register selected by the argument.
- R6: Operation 0x05 reads the slot just below the stack pointer into the temporary register and leaves the stack pointer unchanged.
- R7: Operation 0x06 copies the temporary register into the selected register. Select value 0 is the program counter (a jump), 1 is the stack pointer, and 2 up to 2+NUM_GPR-1 are the general registers. A read of any other select value returns 0, and a write to one is ignored.
- R8: Operation 0x08 writes the temporary register to the slot at the stack pointer and then increments the stack pointer.
- R9: Operations 0x00 and 0x09, and every operation not listed above, change no register except the program counter and make no bus write.
- R10: While the program counter equals 0xFFFF, halted is high, no state changes and no bus write is made.
- R11: The bus write strobe is high only in the execute cycle of operations 0x01, 0x02 and 0x08. The bus address of a slot is STACK_BASE plus the slot index, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | 16 | Program store byte address (the program counter) |
| prog_byte | input | 8 | Program byte at prog_addr, valid in the same cycle |
| bus_addr | output | 16 | Data bus word address |
| bus_wdata | output | 16 | Data bus write value |
| bus_we | output | 1 | Data bus write strobe |
| bus_rdata | input | 16 | Data bus read data for bus_addr, valid in the same cycle |
| halted | output | 1 | High while the program counter equals 0xFFFF |

## Verification
The embedded assertions check on every cycle that the fetch state machine branches on bit 7 of the opcode byte. They also check that every push raises the stack pointer by one and every pop lowers it by one with wraparound, that the write strobe appears only in the execute state, and that a halted core holds its counters and stays off the bus. What lands in memory can only be shown by the bench's programs, which a behavioural reference model follows cycle by cycle. That covers the argument byte order, register selection (including ignored select values and jumps), stack-pointer wrap below zero, peek data and the final stack contents.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_ARGH = 2'd1,
    ST_ARGL = 2'd2,
    ST_EXEC = 2'd3
  } stk_state_e;

  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_PUSH_ARG = 7'h01;
  localparam logic [6:0] OP_POP      = 7'h02;
  localparam logic [6:0] OP_LD_IMM   = 7'h03;
  localparam logic [6:0] OP_LD_REG   = 7'h04;
  localparam logic [6:0] OP_PEEK     = 7'h05;
  localparam logic [6:0] OP_ST_REG   = 7'h06;
  localparam logic [6:0] OP_PUSH_TMP = 7'h08;

  function automatic logic [WORD_W-1:0] wrap_inc(input logic [WORD_W-1:0] v);
    return v + WORD_W'(1);
  endfunction

  function automatic logic [WORD_W-1:0] wrap_dec(input logic [WORD_W-1:0] v);
    return v - WORD_W'(1);
  endfunction

  function automatic logic [WORD_W-1:0] slot_addr(input logic [WORD_W-1:0] base,
                                                  input logic [WORD_W-1:0] idx);
    return base + idx;
  endfunction

endpackage

// File: rtl/stk_fetch.sv
module stk_fetch
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [7:0]        prog_byte,
  output stk_state_e        state_o,
  output logic [6:0]        op_o,
  output logic [WORD_W-1:0] arg_o,
  output logic              adv_pc_o
);

  stk_state_e state_q;
  logic       short_fetch;
  logic       long_fetch;

  assign short_fetch = run && (state_q == ST_OPC) && prog_byte[7];
  assign long_fetch  = run && (state_q == ST_OPC) && !prog_byte[7];
  assign adv_pc_o    = run && (state_q != ST_EXEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OPC;
      op_o    <= '0;
      arg_o   <= '0;
    end else if (run) begin
      case (state_q)
        ST_OPC: begin
          op_o <= prog_byte[6:0];
          if (prog_byte[7]) begin
            arg_o   <= '0;
            state_q <= ST_EXEC;
          end else begin
            state_q <= ST_ARGH;
          end
        end
        ST_ARGH: begin
          arg_o[WORD_W-1:8] <= prog_byte;
          state_q           <= ST_ARGL;
        end
        ST_ARGL: begin
          arg_o[7:0] <= prog_byte;
          state_q    <= ST_EXEC;
        end
        default: state_q <= ST_OPC;
      endcase
    end
  end

  assign state_o = state_q;

  assert_short_op_R2: assert property (@(posedge clk) disable iff (rst)
    short_fetch |=> (state_q == ST_EXEC) && (arg_o == '0));

  assert_long_op_R2: assert property (@(posedge clk) disable iff (rst)
    long_fetch |=> (state_q == ST_ARGH));

endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter int NUM_GPR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_pc,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] sel,
  input  logic [WORD_W-1:0] wr_val,
  input  logic              sp_load,
  input  logic [WORD_W-1:0] sp_nxt,
  input  logic              tmp_load,
  input  logic [WORD_W-1:0] tmp_nxt,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] sp,
  output logic [WORD_W-1:0] tmp,
  output logic [WORD_W-1:0] rd_val,
  output logic              halted
);

  localparam int SEL_PC   = 0;
  localparam int SEL_SP   = 1;
  localparam int SEL_GPR0 = 2;

  logic [WORD_W-1:0] gpr [NUM_GPR];
  logic              wr_pc;
  logic              wr_sp;

  assign halted = (pc == '1);
  assign wr_pc  = wr_en && (sel == WORD_W'(SEL_PC));
  assign wr_sp  = wr_en && (sel == WORD_W'(SEL_SP));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (!halted) begin
      if (wr_pc)       pc <= wr_val;
      else if (adv_pc) pc <= wrap_inc(pc);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (!halted) begin
      if (wr_sp)        sp <= wr_val;
      else if (sp_load) sp <= sp_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       tmp <= '0;
    else if (!halted && tmp_load)  tmp <= tmp_nxt;
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)
        gpr[g] <= '0;
      else if (!halted && wr_en && (sel == WORD_W'(SEL_GPR0 + g)))
        gpr[g] <= wr_val;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel == WORD_W'(SEL_PC)) rd_val = pc;
    if (sel == WORD_W'(SEL_SP)) rd_val = sp;
    for (int g = 0; g < NUM_GPR; g++) begin
      if (sel == WORD_W'(SEL_GPR0 + g)) rd_val = gpr[g];
    end
  end

  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc) && $stable(sp) && $stable(tmp));

endmodule

// File: rtl/stk_exec.sv
module stk_exec
  import stk_pkg::*;
#(
  parameter logic [WORD_W-1:0] STACK_BASE = 16'h8000
) (
  input  logic              run,
  input  stk_state_e        state,
  input  logic [6:0]        op,
  input  logic [WORD_W-1:0] arg,
  input  logic [WORD_W-1:0] sp,
  input  logic [WORD_W-1:0] tmp,
  input  logic [WORD_W-1:0] reg_rd,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              sp_load,
  output logic [WORD_W-1:0] sp_nxt,
  output logic              tmp_load,
  output logic [WORD_W-1:0] tmp_nxt,
  output logic              reg_wr,
  output logic              push_ev,
  output logic              pop_ev
);

  always_comb begin
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    sp_load   = 1'b0;
    sp_nxt    = sp;
    tmp_load  = 1'b0;
    tmp_nxt   = tmp;
    reg_wr    = 1'b0;
    push_ev   = 1'b0;
    pop_ev    = 1'b0;
    if (run && state == ST_EXEC) begin
      case (op)
        OP_PUSH_ARG, OP_PUSH_TMP: begin
          bus_addr  = slot_addr(STACK_BASE, sp);
          bus_we    = 1'b1;
          bus_wdata = (op == OP_PUSH_ARG) ? arg : tmp;
          sp_load   = 1'b1;
          sp_nxt    = wrap_inc(sp);
          push_ev   = 1'b1;
        end
        OP_POP: begin
          sp_nxt    = wrap_dec(sp);
          sp_load   = 1'b1;
          bus_addr  = slot_addr(STACK_BASE, wrap_dec(sp));
          bus_we    = 1'b1;
          bus_wdata = '0;
          pop_ev    = 1'b1;
        end
        OP_LD_IMM: begin
          tmp_load = 1'b1;
          tmp_nxt  = arg;
        end
        OP_LD_REG: begin
          tmp_load = 1'b1;
          tmp_nxt  = reg_rd;
        end
        OP_PEEK: begin
          bus_addr = slot_addr(STACK_BASE, wrap_dec(sp));
          tmp_load = 1'b1;
          tmp_nxt  = bus_rdata;
        end
        OP_ST_REG: reg_wr = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter logic [15:0] STACK_BASE = 16'h8000,
  parameter int          NUM_GPR    = 4
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] prog_addr,
  input  logic [7:0]  prog_byte,
  output logic [15:0] bus_addr,
  output logic [15:0] bus_wdata,
  output logic        bus_we,
  input  logic [15:0] bus_rdata,
  output logic        halted
);

  stk_state_e        state;
  logic [6:0]        op;
  logic [WORD_W-1:0] arg;
  logic              adv_pc;
  logic              run;
  logic [WORD_W-1:0] pc, sp, tmp, reg_rd;
  logic              sp_load, tmp_load, reg_wr;
  logic [WORD_W-1:0] sp_nxt, tmp_nxt;
  logic              push_ev, pop_ev;

  assign run       = !halted;
  assign prog_addr = pc;

  stk_fetch u_fetch (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .prog_byte (prog_byte),
    .state_o   (state),
    .op_o      (op),
    .arg_o     (arg),
    .adv_pc_o  (adv_pc)
  );

  stk_exec #(.STACK_BASE(STACK_BASE)) u_exec (
    .run       (run),
    .state     (state),
    .op        (op),
    .arg       (arg),
    .sp        (sp),
    .tmp       (tmp),
    .reg_rd    (reg_rd),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .sp_load   (sp_load),
    .sp_nxt    (sp_nxt),
    .tmp_load  (tmp_load),
    .tmp_nxt   (tmp_nxt),
    .reg_wr    (reg_wr),
    .push_ev   (push_ev),
    .pop_ev    (pop_ev)
  );

  stk_regs #(.NUM_GPR(NUM_GPR)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .adv_pc   (adv_pc),
    .wr_en    (reg_wr),
    .sel      (arg),
    .wr_val   (tmp),
    .sp_load  (sp_load),
    .sp_nxt   (sp_nxt),
    .tmp_load (tmp_load),
    .tmp_nxt  (tmp_nxt),
    .pc       (pc),
    .sp       (sp),
    .tmp      (tmp),
    .rd_val   (reg_rd),
    .halted   (halted)
  );

  // R3 and R8 share the push path
  assert_push_sp_R3: assert property (@(posedge clk) disable iff (rst)
    push_ev |=> sp == $past(sp) + 16'd1);

  assert_pop_sp_R4: assert property (@(posedge clk) disable iff (rst)
    pop_ev |=> sp == $past(sp) - 16'd1);

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    halted |-> !bus_we);

  assert_we_exec_R11: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> (state == ST_EXEC) && $onehot0({push_ev, pop_ev}) && (push_ev || pop_ev));

endmodule

// File: tb/stk_core_tb.sv
module stk_core_tb_top;

  localparam logic [15:0] BASE = 16'h8000;
  localparam logic [15:0] PRE  = 16'h5A5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] prog_addr, bus_addr, bus_wdata, bus_rdata;
  logic [7:0]  prog_byte;
  logic        bus_we, halted;

  logic [7:0]  pmem [256];
  logic [15:0] dmem [256];

  int checks = 0;
  int errors = 0;
  int wcount = 0;
  int pa     = 0;

  always #5 clk = ~clk;

  assign prog_byte = pmem[prog_addr[7:0]];
  assign bus_rdata = dmem[bus_addr[7:0]];

  stk_core dut_i (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_byte(prog_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) dmem[i] <= PRE;
    end else if (bus_we) begin
      dmem[bus_addr[7:0]] <= bus_wdata;
    end
  end

  // behavioural reference model
  int          m_st;
  logic [6:0]  m_op;
  logic [15:0] m_pc, m_sp, m_tmp, m_arg;
  logic [15:0] m_gpr [4];
  logic [15:0] mmem [256];

  function automatic logic [15:0] m_read(input logic [15:0] s);
    if (s == 0) return m_pc;
    if (s == 1) return m_sp;
    if (s >= 2 && s <= 5) return m_gpr[s-2];
    return 16'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_op = 0; m_pc = 0; m_sp = 0; m_tmp = 0; m_arg = 0;
      for (int i = 0; i < 4; i++) m_gpr[i] = 0;
      for (int i = 0; i < 256; i++) mmem[i] = PRE;
    end else if (m_pc != 16'hFFFF) begin
      logic [7:0] b;
      logic [15:0] t;
      b = pmem[m_pc[7:0]];
      case (m_st)
        0: begin
          m_pc = m_pc + 1;
          m_op = b[6:0];
          if (b[7]) begin m_arg = 0; m_st = 3; end
          else m_st = 1;
        end
        1: begin m_arg[15:8] = b; m_pc = m_pc + 1; m_st = 2; end
        2: begin m_arg[7:0] = b; m_pc = m_pc + 1; m_st = 3; end
        default: begin
          m_st = 0;
          case (m_op)
            7'h01: begin mmem[m_sp[7:0]] = m_arg; m_sp = m_sp + 1; end
            7'h02: begin m_sp = m_sp - 1; mmem[m_sp[7:0]] = 0; end
            7'h03: m_tmp = m_arg;
            7'h04: m_tmp = m_read(m_arg);
            7'h05: begin t = m_sp - 1; m_tmp = mmem[t[7:0]]; end
            7'h06: begin
              if (m_arg == 0) m_pc = m_tmp;
              else if (m_arg == 1) m_sp = m_tmp;
              else if (m_arg >= 2 && m_arg <= 5) m_gpr[m_arg-2] = m_tmp;
            end
            7'h08: begin mmem[m_sp[7:0]] = m_tmp; m_sp = m_sp + 1; end
            default: ;
          endcase
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      logic        e_we, e_addr_valid;
      logic [15:0] e_addr, e_wd;
      e_we = 0; e_addr_valid = 0; e_addr = 0; e_wd = 0;
      if (m_st == 3 && m_pc != 16'hFFFF) begin
        case (m_op)
          7'h01: begin e_we = 1; e_addr_valid = 1; e_addr = BASE + m_sp; e_wd = m_arg; end
          7'h08: begin e_we = 1; e_addr_valid = 1; e_addr = BASE + m_sp; e_wd = m_tmp; end
          7'h02: begin e_we = 1; e_addr_valid = 1; e_addr = BASE + m_sp - 1; e_wd = 0; end
          7'h05: begin e_addr_valid = 1; e_addr = BASE + m_sp - 1; end
          default: ;
        endcase
      end
      if (bus_we) wcount++;
      chk(prog_addr == m_pc, "R2 prog_addr", prog_addr, m_pc);
      chk(halted == (m_pc == 16'hFFFF), "R10 halted", halted, m_pc == 16'hFFFF);
      chk(bus_we == e_we, "R11 bus_we", bus_we, e_we);
      if (e_addr_valid) chk(bus_addr == e_addr, "R11 bus_addr", bus_addr, e_addr);
      if (e_we) chk(bus_wdata == e_wd, "R3/R4/R8 bus_wdata", bus_wdata, e_wd);
    end
  end

  task automatic begin_prog();
    @(negedge clk);
    rst = 1;
    for (int i = 0; i < 256; i++) pmem[i] = 8'h80;
    pa = 0;
  endtask

  task automatic e1(input logic [7:0] b);
    pmem[pa[7:0]] = b;
    pa++;
  endtask

  task automatic e3(input logic [7:0] b, input logic [15:0] a);
    e1(b); e1(a[15:8]); e1(a[7:0]);
  endtask

  task automatic halt_seq();
    e3(8'h03, 16'hFFFF);
    e3(8'h06, 16'h0000);
  endtask

  task automatic release_rst();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    wcount = 0;
  endtask

  task automatic wait_halt();
    int n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(halted, "R10 program reached halt", halted, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // ---- P3: reset values and instruction timing ----
    begin_prog();
    e1(8'h88);              // push tmp (reset value)
    e3(8'h03, 16'h0001);
    e1(8'h80);
    e3(8'h04, 16'h0002);    // tmp = first general register
    e1(8'h88);
    halt_seq();
    release_rst();
    chk(prog_addr == 16'h0, "R1 reset pc", prog_addr, 0);
    chk(!halted, "R1 reset halted", halted, 0);
    chk(!bus_we, "R1 reset no write", bus_we, 0);
    @(negedge clk);
    chk(prog_addr == 16'h1, "R2 short op pc+1", prog_addr, 1);
    chk(bus_we && bus_addr == BASE && bus_wdata == 0, "R1 R8 reset sp/tmp push",
        bus_wdata, 0);
    repeat (4) @(negedge clk);
    chk(prog_addr == 16'h4, "R2 long op pc+3 after four cycles", prog_addr, 4);
    repeat (2) @(negedge clk);
    chk(prog_addr == 16'h5, "R2 short op two cycles", prog_addr, 5);
    wait_halt();
    @(negedge clk);
    chk(dmem[0] == 16'h0, "R1 reset tmp", dmem[0], 0);
    chk(dmem[1] == 16'h0, "R1 reset general register", dmem[1], 0);

    // ---- P1: main operations ----
    begin_prog();
    e3(8'h01, 16'h1234);
    e3(8'h01, 16'hBEEF);
    e1(8'h85);              // peek
    e1(8'h88);
    e1(8'h82);              // pop
    e3(8'h03, 16'h0007);
    e3(8'h06, 16'h0002);
    e3(8'h03, 16'h0000);
    e3(8'h04, 16'h0002);
    e1(8'h88);
    e3(8'h04, 16'h0001);    // tmp = sp
    e1(8'h88);
    e3(8'h03, 16'h1234);
    e3(8'h06, 16'h0009);    // ignored write
    e3(8'h04, 16'h0009);    // reads 0
    e1(8'h88);
    e1(8'h89);
    e3(8'h09, 16'hAABB);
    e3(8'h7F, 16'h1122);
    e1(8'h80);
    halt_seq();
    release_rst();
    wait_halt();
    @(negedge clk);
    chk(dmem[0] == 16'h1234, "R3 push argument", dmem[0], 16'h1234);
    chk(dmem[1] == 16'hBEEF, "R2 R3 big-endian argument", dmem[1], 16'hBEEF);
    chk(dmem[2] == 16'h0007, "R4 R5 R7 pop then register round trip", dmem[2], 7);
    chk(dmem[3] == 16'h0003, "R7 read stack pointer", dmem[3], 3);
    chk(dmem[4] == 16'h0000, "R7 out-of-range select", dmem[4], 0);
    chk(dmem[5] == PRE, "R9 no-ops leave memory", dmem[5], PRE);
    chk(wcount == 7, "R9 R11 write count", wcount, 7);
    for (int i = 0; i < 8; i++)
      chk(dmem[i] == mmem[i], "R6 model memory match", dmem[i], mmem[i]);

    // ---- P2: wraparound, stack pointer load, jump ----
    begin_prog();
    e1(8'h82);              // sp 0 -> FFFF
    e3(8'h03, 16'h0005);
    e1(8'h88);
    e3(8'h01, 16'h5555);
    e1(8'h85);
    e3(8'h06, 16'h0003);
    e3(8'h03, 16'h0040);
    e3(8'h06, 16'h0001);    // sp = 0x40
    e3(8'h04, 16'h0003);
    e1(8'h88);
    e3(8'h03, 16'h0030);
    e3(8'h06, 16'h0000);    // jump
    pa = 16'h30;
    e3(8'h03, 16'h0009);
    e1(8'h88);
    halt_seq();
    release_rst();
    wait_halt();
    @(negedge clk);
    chk(dmem[8'hFF] == 16'h0005, "R4 pop wraps below zero", dmem[8'hFF], 5);
    chk(dmem[0] == 16'h5555, "R3 push after wrap", dmem[0], 16'h5555);
    chk(dmem[8'h40] == 16'h5555, "R6 R7 peek and sp load", dmem[8'h40], 16'h5555);
    chk(dmem[8'h41] == 16'h0009, "R7 jump target executed", dmem[8'h41], 9);
    begin
      int w0;
      w0 = wcount;
      repeat (10) @(negedge clk);
      chk(halted && prog_addr == 16'hFFFF, "R10 halt held", prog_addr, 16'hFFFF);
      chk(wcount == w0, "R10 no writes while halted", wcount, w0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule